// File: doc/BRIEF.md
# Bit-Serial Signed and Unsigned Comparator with Serial Adder

This block consumes two operands one bit per clock cycle, least significant bit first, and has no fixed word length. Each accepted bit pair passes through a single full adder whose carry is kept in a register for the next bit. Two running flags are kept beside it: one for equality and one for unsigned less-than.

On every accepted cycle the block reports four results for the word seen so far. The current bit is taken as the top bit of a word whose width equals the number of bits accepted since the word began. The results are the sum bit at that index, an equality flag, an unsigned less-than flag and a signed (two's complement) less-than flag. For a signed result, the current bit pair is read as the sign bits.

A word begins with a start pulse. The start pulse may come together with the first valid bit, and that bit is then index 0. It may also come on its own, and the state is then cleared for the next bit. Cycles without the valid strobe leave all state untouched. A caller reads the flags of a width-k word on the k-th accepted bit, which is index k−1.

Top module: `lsbs_cmp`

## Requirements
- R1: After reset, the first valid bit (start low) is treated as index 0: carry-in 0, prior equality 1, prior unsigned less-than 0.
- R2: A start pulse with the valid strobe high makes that bit index 0 of a new word, whatever state was left by earlier bits.
- R3: A start pulse with the valid strobe low clears the state, so the next valid bit behaves as index 0.
- R4: On the cycle of accepted bit index i, sum_o equals bit i of A+B, where A and B are the operand bits accepted since the word began.
- R5: eq_o is 1 exactly when the low i+1 bits of A and B are all equal.
- R6: ult_o is 1 exactly when the low i+1 bits of A, read unsigned, are less than those of B.
- R7: slt_o is 1 exactly when the low i+1 bits of A, read as two's complement with bit i as the sign, are less than those of B.
- R8: While vld_i is low and start_i is low, the operand bits have no effect. The results of later valid bits are the same as if those cycles had not occurred.
- R9: The results depend on the current a_i and b_i in the same cycle, with no register between the operand inputs and the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new word (clears state) |
| vld_i | input | 1 | Operand bits on this cycle are accepted |
| a_i | input | 1 | Operand A bit, LSB first |
| b_i | input | 1 | Operand B bit, LSB first |
| sum_o | output | 1 | Sum bit at the current index |
| eq_o | output | 1 | A equals B over bits seen so far |
| ult_o | output | 1 | A below B, unsigned, current width |
| slt_o | output | 1 | A below B, signed, current bit as sign |

## Verification
Random operand pairs of widths 1 to 16 are checked against integer arithmetic at every intermediate width. Checking each width catches a flag that is right only at the final bit, and catches errors in the sign reinterpretation. Corner pairs are also driven: equal words, all-ones against zero, and the most negative value against the most positive. These separate the signed flag from the unsigned one and expose a carry that never clears. Idle cycles with garbage bits placed inside words test that state is held. Clearing without a valid bit, and back-to-back words that begin with a start on a valid bit, test that no carry or flag leaks from one word into the next.

// File: rtl/lsbs_pkg.sv
package lsbs_pkg;
  typedef struct packed {
    logic carry;
    logic eq;
    logic ult;
  } lsbs_state_t;

  localparam lsbs_state_t LSBS_CLEAR = '{carry: 1'b0, eq: 1'b1, ult: 1'b0};
endpackage

// File: rtl/lsbs_add_slice.sv
module lsbs_add_slice (
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);
  always_comb begin
    sum_o  = a_i ^ b_i ^ cin_i;
    cout_o = (a_i & b_i) | (cin_i & (a_i | b_i));
  end
endmodule

// File: rtl/lsbs_eq_track.sv
module lsbs_eq_track (
  input  logic a_i,
  input  logic b_i,
  input  logic eq_prev_i,
  output logic eq_o
);
  always_comb eq_o = eq_prev_i & ~(a_i ^ b_i);
endmodule

// File: rtl/lsbs_lt_track.sv
module lsbs_lt_track (
  input  logic a_i,
  input  logic b_i,
  input  logic ult_prev_i,
  output logic ult_o,
  output logic slt_o
);
  logic a_gt_bit;
  logic a_ge_bit;
  always_comb begin
    a_gt_bit = a_i & ~b_i;
    a_ge_bit = a_i | ~b_i;
    // unsigned: current bit dominates, ties pass the lower-bit result
    ult_o = (~a_i & b_i) | (~a_gt_bit & ult_prev_i);
    // signed: current bit is the sign, so a set A sign means A is smaller
    slt_o = a_gt_bit | (a_ge_bit & ult_prev_i);
  end
endmodule

// File: rtl/lsbs_cmp.sv
module lsbs_cmp
  import lsbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic vld_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic eq_o,
  output logic ult_o,
  output logic slt_o
);
  lsbs_state_t st_q;
  lsbs_state_t st_prev;
  lsbs_state_t st_bit;
  lsbs_state_t st_d;
  logic        st_en;

  // a start on this cycle makes the incoming bit index 0
  always_comb st_prev = start_i ? LSBS_CLEAR : st_q;

  lsbs_add_slice u_add (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (st_prev.carry),
    .sum_o  (sum_o),
    .cout_o (st_bit.carry)
  );

  lsbs_eq_track u_eq (
    .a_i       (a_i),
    .b_i       (b_i),
    .eq_prev_i (st_prev.eq),
    .eq_o      (st_bit.eq)
  );

  lsbs_lt_track u_lt (
    .a_i        (a_i),
    .b_i        (b_i),
    .ult_prev_i (st_prev.ult),
    .ult_o      (st_bit.ult),
    .slt_o      (slt_o)
  );

  always_comb begin
    eq_o  = st_bit.eq;
    ult_o = st_bit.ult;
  end

  // next state and enable
  always_comb begin
    st_en = vld_i | start_i;
    st_d  = vld_i ? st_bit : LSBS_CLEAR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LSBS_CLEAR;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/lsbs_cmp_chk.sv
module lsbs_cmp_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic vld_i,
  input logic a_i,
  input logic b_i,
  input logic sum_o,
  input logic eq_o,
  input logic ult_o,
  input logic slt_o,
  input logic [2:0] st_q
);
  // R3: a lone start leaves the cleared state behind
  a_r3_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !vld_i) |=> (st_q == 3'b010));

  // R8: idle cycles keep the state
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !vld_i) |=> $stable(st_q));

  // R5: once unequal, stays unequal until a new word
  a_r5_eq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !eq_o) |=> (!(vld_i && !start_i) || !eq_o));

  // R6/R7: equal words are never less-than
  a_r6_eq_excl_lt: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && eq_o) |-> (!ult_o && !slt_o));

  // R4: a generated carry shows up in the next bit's sum
  a_r4_carry_gen: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && a_i && b_i) |=> ((vld_i && !start_i) -> (sum_o == ~(a_i ^ b_i))));

  // R4: a killed carry does not show up
  a_r4_carry_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !a_i && !b_i) |=> ((vld_i && !start_i) -> (sum_o == (a_i ^ b_i))));

  // R2: a new word's first bit sees no history
  a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && start_i) |-> (eq_o == (a_i == b_i) && sum_o == (a_i ^ b_i)));
endmodule

bind lsbs_cmp lsbs_cmp_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .vld_i   (vld_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .sum_o   (sum_o),
  .eq_o    (eq_o),
  .ult_o   (ult_o),
  .slt_o   (slt_o),
  .st_q    (st_q)
);

// File: tb/lsbs_cmp_bench.sv
`timescale 1ns/1ps
module lsbs_cmp_bench;
  logic clk = 1'b0;
  logic rst_n, start_i, vld_i, a_i, b_i;
  logic sum_o, eq_o, ult_o, slt_o;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lsbs_cmp u_lsbs_cmp (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vld_i(vld_i),
    .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .eq_o(eq_o),
    .ult_o(ult_o), .slt_o(slt_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, settle, return
  task automatic put(input logic st, input logic v, input logic a, input logic b);
    @(negedge clk);
    start_i = st; vld_i = v; a_i = a; b_i = b;
    #1;
  endtask

  // R4 R5 R6 R7: reference results at width i+1
  task automatic check_bit(input int av, input int bv, input int i, input string req);
    int m, am, bm, sa, sb;
    m  = (1 << (i + 1)) - 1;
    am = av & m; bm = bv & m;
    sa = ((am >> i) & 1) ? am - (1 << (i + 1)) : am;
    sb = ((bm >> i) & 1) ? bm - (1 << (i + 1)) : bm;
    check({req, "/R4"}, "sum", sum_o, 1'(((av + bv) >> i) & 1));
    check({req, "/R5"}, "eq",  eq_o,  am == bm);
    check({req, "/R6"}, "ult", ult_o, am < bm);
    check({req, "/R7"}, "slt", slt_o, sa < sb);
  endtask

  task automatic word(input int av, input int bv, input int w, input bit gaps, input string req);
    for (int i = 0; i < w; i++) begin
      put(i == 0, 1'b1, 1'((av >> i) & 1), 1'((bv >> i) & 1));
      check_bit(av, bv, i, req);
      if (gaps && ($urandom % 2 == 0))
        put(1'b0, 1'b0, 1'($urandom), 1'($urandom)); // R8 garbage while idle
    end
    put(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; start_i = 0; vld_i = 0; a_i = 0; b_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    put(1'b0, 1'b1, 1'b0, 1'b1); // R1 first bit without start
    check("R1", "sum", sum_o, 1'b1);
    check("R1", "eq",  eq_o,  1'b0);
    check("R1", "ult", ult_o, 1'b1);
    check("R1", "slt", slt_o, 1'b0);
    // R9: same cycle, flip operands without a clock edge
    a_i = 1'b1; b_i = 1'b0; #0.5;
    check("R9", "slt_comb", slt_o, 1'b1);
    check("R9", "ult_comb", ult_o, 1'b0);
    put(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_random_words();
    for (int n = 0; n < 300; n++) begin
      int w = 1 + ($urandom % 16);
      word(int'($urandom & 16'hFFFF), int'($urandom & 16'hFFFF), w, 1'b0, "R2");
    end
  endtask

  task automatic t_gap_hold();
    for (int n = 0; n < 60; n++)
      word(int'($urandom & 16'hFFFF), int'($urandom & 16'hFFFF), 16, 1'b1, "R8");
  endtask

  task automatic t_corners();
    word(16'hFFFF, 16'h0000, 16, 1'b0, "R7");
    word(16'h8000, 16'h7FFF, 16, 1'b0, "R7");
    word(16'h7FFF, 16'h8000, 16, 1'b0, "R6");
    word(16'h5A5A, 16'h5A5A, 16, 1'b0, "R5");
    word(16'hFFFF, 16'h0001, 16, 1'b0, "R4");
  endtask

  task automatic t_clear_no_valid();
    put(1'b1, 1'b1, 1'b1, 1'b1);
    put(1'b0, 1'b1, 1'b0, 1'b1); // leaves carry 1, eq 0, ult 1
    put(1'b1, 1'b0, 1'b1, 1'b0); // R3 lone clear
    put(1'b0, 1'b1, 1'b0, 1'b0);
    check("R3", "sum", sum_o, 1'b0);
    check("R3", "eq",  eq_o,  1'b1);
    check("R3", "ult", ult_o, 1'b0);
    check("R3", "slt", slt_o, 1'b0);
    put(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    put(1'b1, 1'b1, 1'b1, 1'b1);
    put(1'b0, 1'b1, 1'b0, 1'b1); // dirty state, then immediate new word
    put(1'b1, 1'b1, 1'b0, 1'b0);
    check("R2", "sum", sum_o, 1'b0);
    check("R2", "eq",  eq_o,  1'b1);
    check("R2", "ult", ult_o, 1'b0);
    check("R2", "slt", slt_o, 1'b0);
    put(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_clear_no_valid();
    t_back_to_back();
    t_corners();
    t_random_words();
    t_gap_hold();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule